// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches recent virtual-page to physical-frame translations in front of a page table. A lookup compares the page-number field of the virtual address against every valid entry in the same cycle. On a hit, the stored frame number is joined to the unchanged page offset to form the physical address. On a miss, the caller has to consult the page table in memory and then install the missing pair through the fill port.

Each entry also holds a writable flag. A store to a page marked read-only gives a protection fault and no address. The buffer has a fixed number of slots. A fill for a page that is already held replaces that slot in place. A fill for a new page takes the lowest-numbered empty slot. When no slot is empty, the fill takes the slot named by a rotating replacement pointer. A flush empties the whole buffer in one cycle, for use on a context switch.

Top module: `page_tlb`

## Requirements
- R1: The virtual address is `{page, offset}`, with the page number in the upper PAGE_W bits and the offset in the lower OFF_W bits. On a hit, `physAddr` equals `{frame, offset}` with the offset passed through unchanged.
- R2: A lookup is resolved in the cycle it is presented, with all entries searched together. An entry installed by a fill at a clock edge is found by a lookup in the following cycle.
- R3: When `lookupValid` is high and no valid entry holds the requested page, `miss` is 1, `hit` and `protFault` are 0, and `physAddr` is 0. Exactly one of hit, miss and protFault is high for every presented lookup.
- R4: A lookup with `lookupWrite`=1 that matches an entry whose writable flag is 0 raises `protFault`, with `hit`=0 and `physAddr`=0. A read of the same entry hits, and a write to an entry with writable=1 hits.
- R5: After reset, every entry is invalid, so any lookup misses. The replacement pointer starts at slot 0.
- R6: A fill for a page not present goes to the lowest-indexed invalid slot and does not move the replacement pointer.
- R7: When every slot is valid, a fill for a new page overwrites the slot at the replacement pointer. The pointer then advances by one and wraps from the last slot to slot 0.
- R8: `flush` invalidates all entries at the next edge. A fill presented in the same cycle as a flush is discarded. A flush leaves the replacement pointer unchanged.
- R9: A fill whose page matches a valid entry overwrites that entry's frame and writable flag in place. It uses no new slot and does not move the replacement pointer.
- R10: While `lookupValid` is 0, `hit`, `miss` and `protFault` are all 0 and `physAddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Invalidate every entry |
| fillValid | input | 1 | Install a translation this cycle |
| fillPage | input | PAGE_W | Page number to install |
| fillFrame | input | FRAME_W | Frame number to install |
| fillWritable | input | 1 | 1 = page may be written, 0 = read-only |
| lookupValid | input | 1 | A translation request is present |
| lookupWrite | input | 1 | The request is a store |
| lookupVaddr | input | PAGE_W+OFF_W | Virtual address to translate |
| hit | output | 1 | Translation found and access allowed |
| miss | output | 1 | No entry holds the page; the page table must be consulted |
| protFault | output | 1 | Store to a read-only page |
| physAddr | output | FRAME_W+OFF_W | Translated address, 0 unless hit |

## Verification
The lookup outputs are combinational from the stored entries, so each result is due in the same cycle as its request. A fill or flush changes what lookups return only after the next rising edge. The bench drives every input on the falling edge and samples lookup results 1 ns later, which is still inside the same cycle. As a result, each fill or flush has been applied at exactly one rising edge before the first lookup that checks it. Replacement order is checked through eviction only: the bench predicts which earlier page must start missing after a fill into a full buffer.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clearAll;  // drop every valid bit
    logic load;      // write one slot at loadIdx
  } tlbStrobe_t;
endpackage

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PAGE_W  = 10,
  parameter int OFF_W   = 12,
  parameter int FRAME_W = 8,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int VA_W   = PAGE_W + OFF_W,
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  tlbStrobe_t         strobe,
  input  logic [IDX_W-1:0]   loadIdx,
  input  logic [PAGE_W-1:0]  fillPage,
  input  logic [FRAME_W-1:0] fillFrame,
  input  logic               fillWritable,
  input  logic               lookupValid,
  input  logic               lookupWrite,
  input  logic [VA_W-1:0]    lookupVaddr,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] fillMatch,
  output logic               hit,
  output logic               miss,
  output logic               protFault,
  output logic [PA_W-1:0]    physAddr
);
  logic [ENTRIES-1:0] validQ;
  logic [ENTRIES-1:0] writableQ;
  logic [PAGE_W-1:0]  pageQ  [ENTRIES];
  logic [FRAME_W-1:0] frameQ [ENTRIES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ    <= '0;
      writableQ <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        pageQ[i]  <= '0;
        frameQ[i] <= '0;
      end
    end else if (strobe.clearAll) begin
      validQ <= '0;
    end else if (strobe.load) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (loadIdx == IDX_W'(i)) begin
          validQ[i]    <= 1'b1;
          writableQ[i] <= fillWritable;
          pageQ[i]     <= fillPage;
          frameQ[i]    <= fillFrame;
        end
      end
    end
  end

  logic [PAGE_W-1:0]  lookPage;
  logic [ENTRIES-1:0] lookMatch;
  assign lookPage = lookupVaddr[OFF_W +: PAGE_W];

  // Parallel comparators, one pair per slot
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lookMatch[g] = validQ[g] && (pageQ[g] == lookPage);
    assign fillMatch[g] = validQ[g] && (pageQ[g] == fillPage);
  end

  // Fills never create duplicates, so an OR mux over the match vector is safe
  logic [FRAME_W-1:0] selFrame;
  logic               selWritable;
  always_comb begin
    selFrame    = '0;
    selWritable = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      selFrame    = selFrame | ({FRAME_W{lookMatch[i]}} & frameQ[i]);
      selWritable = selWritable | (lookMatch[i] & writableQ[i]);
    end
  end

  logic anyMatch, denied;
  assign anyMatch  = |lookMatch;
  assign denied    = lookupWrite && !selWritable;
  assign hit       = lookupValid && anyMatch && !denied;
  assign protFault = lookupValid && anyMatch && denied;
  assign miss      = lookupValid && !anyMatch;
  assign physAddr  = hit ? {selFrame, lookupVaddr[OFF_W-1:0]} : '0;
  assign validVec  = validQ;
endmodule

// File: rtl/tlb_control.sv
module tlb_control
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flush,
  input  logic               fillValid,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] fillMatch,
  output tlbStrobe_t         strobe,
  output logic [IDX_W-1:0]   loadIdx
);
  logic [IDX_W-1:0] rrPtr, dupIdx, freeIdx;
  logic dupFound, freeFound, advance;

  always_comb begin
    dupFound  = 1'b0;
    dupIdx    = '0;
    freeFound = 1'b0;
    freeIdx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (fillMatch[i]) begin
        dupFound = 1'b1;
        dupIdx   = IDX_W'(i);
      end
      if (!validVec[i]) begin
        freeFound = 1'b1;
        freeIdx   = IDX_W'(i);  // downward scan leaves the lowest index
      end
    end
  end

  always_comb begin
    strobe.clearAll = flush;
    strobe.load     = fillValid && !flush;
    if (dupFound)       loadIdx = dupIdx;
    else if (freeFound) loadIdx = freeIdx;
    else                loadIdx = rrPtr;
  end

  assign advance = fillValid && !flush && !dupFound && !freeFound;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        rrPtr <= '0;
    else if (advance) rrPtr <= (rrPtr == IDX_W'(ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
  end
endmodule

// File: rtl/page_tlb.sv
module page_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PAGE_W  = 10,
  parameter int OFF_W   = 12,
  parameter int FRAME_W = 8,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int VA_W   = PAGE_W + OFF_W,
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flush,
  input  logic               fillValid,
  input  logic [PAGE_W-1:0]  fillPage,
  input  logic [FRAME_W-1:0] fillFrame,
  input  logic               fillWritable,
  input  logic               lookupValid,
  input  logic               lookupWrite,
  input  logic [VA_W-1:0]    lookupVaddr,
  output logic               hit,
  output logic               miss,
  output logic               protFault,
  output logic [PA_W-1:0]    physAddr
);
  tlbStrobe_t         strobe;
  logic [IDX_W-1:0]   loadIdx;
  logic [ENTRIES-1:0] validVec, fillMatch;

  tlb_control #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rstN(rstN), .flush(flush), .fillValid(fillValid),
    .validVec(validVec), .fillMatch(fillMatch),
    .strobe(strobe), .loadIdx(loadIdx)
  );

  tlb_datapath #(
    .ENTRIES(ENTRIES), .PAGE_W(PAGE_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadIdx(loadIdx),
    .fillPage(fillPage), .fillFrame(fillFrame), .fillWritable(fillWritable),
    .lookupValid(lookupValid), .lookupWrite(lookupWrite),
    .lookupVaddr(lookupVaddr), .validVec(validVec), .fillMatch(fillMatch),
    .hit(hit), .miss(miss), .protFault(protFault), .physAddr(physAddr)
  );
endmodule

// File: rtl/page_tlb_checker.sv
module page_tlb_checker #(
  parameter int PAGE_W  = 10,
  parameter int OFF_W   = 12,
  parameter int FRAME_W = 8
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      flush,
  input logic                      fillValid,
  input logic [PAGE_W-1:0]         fillPage,
  input logic [FRAME_W-1:0]        fillFrame,
  input logic                      lookupValid,
  input logic                      lookupWrite,
  input logic [PAGE_W+OFF_W-1:0]   lookupVaddr,
  input logic                      hit,
  input logic                      miss,
  input logic                      protFault,
  input logic [FRAME_W+OFF_W-1:0]  physAddr
);
  p_one_result_r3: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |-> $countones({hit, miss, protFault}) == 1);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |-> (!hit && !miss && !protFault && physAddr == '0));

  p_offset_kept_r1: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> physAddr[OFF_W-1:0] == lookupVaddr[OFF_W-1:0]);

  p_fault_on_store_r4: assert property (@(posedge clk) disable iff (!rstN)
    protFault |-> (lookupWrite && physAddr == '0));

  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (!hit && !protFault));

  p_fill_visible_r2: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && !flush) |=>
      (!(lookupValid && !lookupWrite && lookupVaddr[OFF_W +: PAGE_W] == $past(fillPage))
       || (hit && physAddr[OFF_W +: FRAME_W] == $past(fillFrame))));
endmodule

bind page_tlb page_tlb_checker #(
  .PAGE_W(PAGE_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W)
) u_chk (.*);

// File: tb/page_tlb_tb.sv
module page_tlb_tb;
  localparam int PW = 10;
  localparam int OW = 12;
  localparam int FW = 8;

  typedef struct packed {
    logic          wr;
    logic [PW-1:0] page;
    logic [OW-1:0] off;
    logic [1:0]    kind;   // 0 miss, 1 hit, 2 fault
    logic [FW-1:0] frame;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b0, 10'h001, 12'h123, 2'd1, 8'h11},
    '{1'b1, 10'h001, 12'h000, 2'd1, 8'h11},
    '{1'b0, 10'h3FF, 12'hFFF, 2'd1, 8'hA5},
    '{1'b1, 10'h3FF, 12'h456, 2'd2, 8'h00},
    '{1'b0, 10'h155, 12'h000, 2'd1, 8'h3C},
    '{1'b1, 10'h000, 12'h800, 2'd2, 8'h00},
    '{1'b0, 10'h000, 12'h800, 2'd1, 8'hF0},
    '{1'b0, 10'h002, 12'h001, 2'd0, 8'h00},
    '{1'b1, 10'h200, 12'h7FF, 2'd0, 8'h00},
    '{1'b0, 10'h2AA, 12'h555, 2'd0, 8'h00}
  };

  logic clk = 1'b0;
  logic rstN, flush, fillValid, fillWritable, lookupValid, lookupWrite;
  logic [PW-1:0] fillPage;
  logic [FW-1:0] fillFrame;
  logic [PW+OW-1:0] lookupVaddr;
  logic hit, miss, protFault;
  logic [FW+OW-1:0] physAddr;
  int testCount = 0, failCount = 0;

  always #4 clk = ~clk;

  page_tlb u_dut (
    .clk(clk), .rstN(rstN), .flush(flush), .fillValid(fillValid),
    .fillPage(fillPage), .fillFrame(fillFrame), .fillWritable(fillWritable),
    .lookupValid(lookupValid), .lookupWrite(lookupWrite),
    .lookupVaddr(lookupVaddr), .hit(hit), .miss(miss),
    .protFault(protFault), .physAddr(physAddr)
  );

  task automatic doFill(input logic [PW-1:0] p, input logic [FW-1:0] f,
                        input logic w, input logic fl);
    @(negedge clk);
    fillValid = 1'b1; fillPage = p; fillFrame = f; fillWritable = w; flush = fl;
    @(posedge clk);
    #1 fillValid = 1'b0; flush = 1'b0;
  endtask

  task automatic look(input logic w, input logic [PW-1:0] p, input logic [OW-1:0] o,
                      input int kind, input logic [FW-1:0] f, input string req);
    logic [2:0] expFlags;
    logic [FW+OW-1:0] expPa;
    @(negedge clk);
    lookupValid = 1'b1; lookupWrite = w; lookupVaddr = {p, o};
    #1;
    expFlags = (kind == 1) ? 3'b100 : (kind == 2) ? 3'b001 : 3'b010;
    expPa    = (kind == 1) ? {f, o} : '0;
    testCount++;
    if ({hit, miss, protFault} != expFlags || physAddr != expPa) begin
      failCount++;
      $display("FAIL %s page=%h wr=%0b: got hmf=%b pa=%h, expected hmf=%b pa=%h",
               req, p, w, {hit, miss, protFault}, physAddr, expFlags, expPa);
    end
    lookupValid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    failCount++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    rstN = 1'b0; flush = 1'b0; fillValid = 1'b0; fillWritable = 1'b0;
    fillPage = '0; fillFrame = '0; lookupValid = 1'b0; lookupWrite = 1'b0;
    lookupVaddr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    look(1'b0, 10'h000, 12'h000, 0, 8'h00, "R5 empty after reset");

    // R10: idle request produces nothing
    @(negedge clk);
    lookupValid = 1'b0; lookupWrite = 1'b1; lookupVaddr = 22'h3FFFFF;
    #1 testCount++;
    if (hit || miss || protFault || physAddr != '0) begin
      failCount++;
      $display("FAIL R10 idle: got hmf=%b pa=%h, expected hmf=000 pa=0",
               {hit, miss, protFault}, physAddr);
    end

    // slots 0..3
    doFill(10'h001, 8'h11, 1'b1, 1'b0);
    doFill(10'h3FF, 8'hA5, 1'b0, 1'b0);
    doFill(10'h155, 8'h3C, 1'b1, 1'b0);
    doFill(10'h000, 8'hF0, 1'b0, 1'b0);
    foreach (VECS[i])
      look(VECS[i].wr, VECS[i].page, VECS[i].off, VECS[i].kind, VECS[i].frame,
           "R1/R2/R3/R4 table");

    // R9: overwrite in place, becomes read-only
    doFill(10'h001, 8'h77, 1'b0, 1'b0);
    look(1'b0, 10'h001, 12'hABC, 1, 8'h77, "R9 new frame");
    look(1'b1, 10'h001, 12'hABC, 2, 8'h00, "R9/R4 new flag");

    // R6: slots 4..7; the dup used no slot, so 001 survives
    for (int k = 0; k < 4; k++) doFill(10'h020 + 10'(k), 8'h20 + 8'(k), 1'b1, 1'b0);
    look(1'b0, 10'h001, 12'h001, 1, 8'h77, "R9 no extra slot");
    look(1'b0, 10'h023, 12'h002, 1, 8'h23, "R6 last free slot");

    // R7: full, pointer at 0
    doFill(10'h030, 8'h30, 1'b1, 1'b0);
    look(1'b0, 10'h001, 12'h0, 0, 8'h00, "R7 slot0 evicted");
    look(1'b0, 10'h030, 12'h5, 1, 8'h30, "R7 new entry");
    look(1'b0, 10'h3FF, 12'h5, 1, 8'hA5, "R7 slot1 kept");
    doFill(10'h031, 8'h31, 1'b1, 1'b0);
    look(1'b0, 10'h3FF, 12'h5, 0, 8'h00, "R7 slot1 evicted");
    look(1'b0, 10'h155, 12'h5, 1, 8'h3C, "R7 slot2 kept");

    // R9: dup on a full buffer leaves pointer at 2
    doFill(10'h155, 8'h99, 1'b1, 1'b0);
    look(1'b0, 10'h155, 12'h6, 1, 8'h99, "R9 full overwrite");
    doFill(10'h032, 8'h32, 1'b1, 1'b0);
    look(1'b0, 10'h155, 12'h6, 0, 8'h00, "R9 pointer not moved");
    look(1'b0, 10'h000, 12'h6, 1, 8'hF0, "R9 slot3 kept");

    // R8: flush with simultaneous fill; pointer now 3
    doFill(10'h040, 8'h40, 1'b1, 1'b1);
    look(1'b0, 10'h040, 12'h0, 0, 8'h00, "R8 fill dropped");
    look(1'b0, 10'h030, 12'h0, 0, 8'h00, "R8 cleared");
    look(1'b1, 10'h000, 12'h0, 0, 8'h00, "R8 cleared ro");

    // R6 then R8 pointer kept: refill 0..7, next eviction hits slot 3
    for (int k = 0; k < 8; k++) doFill(10'h050 + 10'(k), 8'h50 + 8'(k), 1'b1, 1'b0);
    for (int k = 0; k < 8; k++)
      look(1'b0, 10'h050 + 10'(k), 12'(k), 1, 8'h50 + 8'(k), "R6 refill");
    doFill(10'h058, 8'h58, 1'b1, 1'b0);
    look(1'b0, 10'h053, 12'h0, 0, 8'h00, "R8 pointer survives flush");
    look(1'b0, 10'h052, 12'h0, 1, 8'h52, "R7 neighbour kept");
    look(1'b1, 10'h058, 12'hFED, 1, 8'h58, "R2 new entry");

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule